// File: doc/BRIEF.md
# Eight-Channel Field Input Deglitch Filter

This block cleans up eight slow digital field inputs before they reach the status logic of an input module. A free-running filter clock is divided by a ratio picked from a pin, either 8 or 64, to produce a one-cycle filter tick. Each channel first passes through a two-flop synchronizer. A new level is adopted only once it has been present at three consecutive ticks. Shorter disturbances are thrown away.

The validated levels are driven on a parallel output that feeds the serial status register, and also on a second output that drives the per-channel monitor LEDs. The channels share the divider but are otherwise independent. A level that reverts before it has been validated restarts that channel's count, so a burst of short glitches never leaks through.

Top module: `field_deglitch_top`

## Requirements
- R1: The eight channels are filtered by identical logic, and a change on one channel never alters the filtered output of any other channel.
- R2: With `div_sel` low, the filter tick occurs once every 8 clock cycles.
- R3: With `div_sel` high, the filter tick occurs once every 64 clock cycles.
- R4: A new raw level on a channel reaches `filt_out` only after the synchronized level has been seen at three consecutive ticks. Take P as the tick period in cycles and e as the clock edge at which the raw level is first sampled. The output is then still old after edge e+2P+1 and has taken the new level by edge e+3P+2.
- R5: If a raw level change reverts before it is validated, the output stays unchanged and the channel's tick count restarts from zero.
- R6: Each raw input is resynchronized through two flip-flops before it is filtered. This adds two cycles to the R4 latency.
- R7: While reset is asserted and just after its release, `filt_out` and `led_out` are all zeros and all tick counts are cleared, whatever the levels on `raw_in`.
- R8: Bit i of `led_out` always equals bit i of `filt_out`.
- R9: The divider produces a single-cycle enable pulse in the clock domain; it does not produce a derived clock.
- R10: A filtered output changes only at a clock edge where the tick is high, and then it takes the synchronized raw level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running filter oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_sel | input | 1 | Divider select: 0 gives ratio 8, 1 gives ratio 64 |
| raw_in | input | 8 | Unsynchronized raw field input levels, bit i is channel i |
| filt_out | output | 8 | Validated channel levels for the status register |
| led_out | output | 8 | Monitor LED drive, one per channel |

## Verification
On every cycle, the assertions check that the tick is one cycle wide and restarts the divider. They also check that a filtered output moves only on a tick and only toward the synchronized level, and that a channel's hit count never reaches the validation limit without flipping the output. Only the bench's scenarios can show the end-to-end latency window for each divider ratio. They also show that glitch bursts of up to two tick periods are rejected, that the channels stay independent, and that the outputs are forced low through reset.

// File: rtl/dglf_pkg.sv
package dglf_pkg;
  localparam int unsigned DGLF_NCH      = 8;
  localparam int unsigned DGLF_RATIO_LO = 8;
  localparam int unsigned DGLF_RATIO_HI = 64;
  localparam int unsigned DGLF_HITS     = 3;
endpackage

// File: rtl/dglf_tick_div.sv
module dglf_tick_div #(
  parameter int unsigned RATIO_LO = 8,
  parameter int unsigned RATIO_HI = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic tick
);
  localparam int unsigned CW = (RATIO_HI > 2) ? $clog2(RATIO_HI) : 1;
  localparam logic [CW-1:0] LIM_LO = CW'(RATIO_LO - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(RATIO_HI - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;

  always_comb begin
    limit = sel ? LIM_HI : LIM_LO;
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: the enable is a single-cycle pulse
  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R2 / R3: a tick restarts the period count
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/dglf_sync2.sv
module dglf_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

  // R6: the stable stage follows the first stage one cycle later
  p_sync_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stab_q == $past(meta_q)));
endmodule

// File: rtl/dglf_chan.sv
module dglf_chan #(
  parameter int unsigned HITS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(HITS + 1);
  localparam logic [CW-1:0] LAST = CW'(HITS - 1);

  logic [CW-1:0] hit_q, hit_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    hit_d = hit_q;
    lvl_d = lvl_q;
    if (din == lvl_q) begin
      hit_d = '0;
    end else if (tick) begin
      if (hit_q == LAST) begin
        lvl_d = din;
        hit_d = '0;
      end else begin
        hit_d = hit_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      lvl_q <= lvl_d;
    end
  end

  assign dout = lvl_q;

  // R10: output moves only on a tick
  p_flip_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> $past(tick));
  // R10: output moves toward the synchronized level
  p_flip_to_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(din)));
  // R4: hit count stays below the validation limit
  p_hit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q <= LAST);
  // R5: agreement between input and output restarts the count
  p_hit_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (din == lvl_q) |=> (hit_q == '0));
endmodule

// File: rtl/field_deglitch_top.sv
module field_deglitch_top
  import dglf_pkg::*;
#(
  parameter int unsigned NCH      = DGLF_NCH,
  parameter int unsigned RATIO_LO = DGLF_RATIO_LO,
  parameter int unsigned RATIO_HI = DGLF_RATIO_HI,
  parameter int unsigned HITS     = DGLF_HITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           div_sel,
  input  logic [NCH-1:0] raw_in,
  output logic [NCH-1:0] filt_out,
  output logic [NCH-1:0] led_out
);
  logic [1:0]     rs_q;
  logic           rst_i_n;
  logic           tick;
  logic [NCH-1:0] sync_lvl;
  logic [NCH-1:0] filt_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  dglf_tick_div #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_div (
    .clk  (clk),
    .rst_n(rst_i_n),
    .sel  (div_sel),
    .tick (tick)
  );

  dglf_sync2 #(.W(NCH)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .d    (raw_in),
    .q    (sync_lvl)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dglf_chan #(.HITS(HITS)) u_ch (
      .clk  (clk),
      .rst_n(rst_i_n),
      .tick (tick),
      .din  (sync_lvl[i]),
      .dout (filt_lvl[i])
    );
  end

  assign filt_out = filt_lvl;
  assign led_out  = filt_lvl;

  // R7: outputs held low while the internal reset is active
  p_reset_low_r7: assert property (@(posedge clk)
    !rst_i_n |-> (filt_out == '0));
endmodule

// File: tb/sim_field_deglitch_top.sv
module sim_field_deglitch_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       div_sel;
  logic [7:0] raw_in;
  logic [7:0] filt_out;
  logic [7:0] led_out;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  bit          done    = 1'b0;

  always #5 clk = ~clk;

  field_deglitch_top u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .raw_in  (raw_in),
    .filt_out(filt_out),
    .led_out (led_out)
  );

  function automatic int unsigned period(input bit sel);
    return sel ? 64 : 8;
  endfunction
  // edges after first sampling edge at which output must still be old
  function automatic int unsigned still_old(input bit sel);
    return 2 * period(sel) + 1;
  endfunction
  function automatic int unsigned must_new(input bit sel);
    return 3 * period(sel) + 2;
  endfunction

  task automatic adv(input int unsigned n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply target; raw is first sampled at the next edge (e); check window
  task automatic window(input string req, input logic [7:0] old_v, input logic [7:0] tgt);
    raw_in = tgt;
    adv(still_old(div_sel) + 1);
    chk(req, filt_out, old_v);
    chk("R8", led_out, filt_out);
    adv(must_new(div_sel) - still_old(div_sel));
    chk(req, filt_out, tgt);
    chk("R8", led_out, filt_out);
  endtask

  logic [7:0] exp_v;

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n   = 1'b0;
    div_sel = 1'b0;
    raw_in  = 8'hFF;
    adv(5);
    // R7: reset forces outputs low regardless of inputs
    chk("R7", filt_out, 8'h00);
    chk("R7", led_out, 8'h00);
    rst_n = 1'b1;
    adv(3);
    chk("R7", filt_out, 8'h00);
    adv(must_new(1'b0) + 4);
    chk("R4", filt_out, 8'hFF);
    exp_v = 8'hFF;

    // R2 R4 R6 R9: ratio 8 window, single channel falls; R1 others hold
    window("R2", exp_v, 8'hF7);
    exp_v = 8'hF7;
    window("R1", exp_v, 8'hF6);
    exp_v = 8'hF6;

    // R5: glitch lasting two tick periods is rejected
    raw_in = exp_v ^ 8'h81;
    adv(2 * period(1'b0));
    raw_in = exp_v;
    adv(must_new(1'b0) + 2);
    chk("R5", filt_out, exp_v);

    // R5: repeated glitches with one-cycle gaps never accumulate
    for (int k = 0; k < 6; k++) begin
      raw_in = exp_v ^ 8'h10;
      adv(2 * period(1'b0) - 1);
      raw_in = exp_v;
      adv(1);
    end
    adv(6);
    chk("R5", filt_out, exp_v);

    // R3: ratio 64 window
    div_sel = 1'b1;
    adv(70);
    window("R3", exp_v, 8'h5A);
    exp_v = 8'h5A;
    raw_in = exp_v ^ 8'h24;
    adv(2 * period(1'b1));
    raw_in = exp_v;
    adv(must_new(1'b1) + 2);
    chk("R5", filt_out, exp_v);
    div_sel = 1'b0;
    adv(70);

    // random rounds: glitch bursts then a real change
    for (int r = 0; r < 24; r++) begin
      logic [7:0] tgt;
      for (int k = 0; k < 4; k++) begin
        raw_in = exp_v ^ 8'($urandom);
        adv(1 + ($urandom % (2 * period(1'b0) - 1)));
        raw_in = exp_v;
        adv(1 + ($urandom % 3));
      end
      chk("R5", filt_out, exp_v);
      tgt = 8'($urandom);
      window("R4", exp_v, tgt);
      exp_v = tgt;
    end

    // R7: reset mid-run clears outputs
    rst_n = 1'b0;
    adv(2);
    chk("R7", filt_out, 8'h00);
    chk("R8", led_out, 8'h00);
    raw_in = 8'h00;
    rst_n  = 1'b1;
    adv(40);
    chk("R7", filt_out, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule